// File: doc/BRIEF.md
# Two-Level Page Table Walker

This block turns a linear address into a physical address. When paging is on, it takes two steps through memory. The first read fetches an entry from a page directory, whose base comes from a root-pointer register. The second read fetches an entry from the page table that the first entry names. The frame number in the second entry is joined with the page offset of the request to form the physical address. When paging is off, the linear address comes back unchanged and no memory read is made.

A translation request is taken only while the walker is idle. Each walk step issues one word read on a simple read port and waits for the read-valid answer before it moves on. Bit 0 of every entry is its present flag. If that flag is clear at either level, the walk stops and a fault pulse is raised. This fault corresponds to page-fault exception 14, and the offending linear address is latched in a fault-address register. Each result is reported by a single-cycle done pulse or fault pulse.

Top module: `pt_walker`

## Requirements
- R1: After reset, `req_ready` is 1 and `rsp_done`, `rsp_fault`, `mem_rd_en` and `fault_lin` are all 0.
- R2: With `paging_en` at 0 when a request is accepted, `rsp_done` pulses in the next cycle with `rsp_phys` equal to the request address, and no memory read is issued.
- R3: With paging on, the cycle after acceptance issues one read at address {root[31:12], lin[31:22], 2'b00}, where root is the root-pointer register.
- R4: Once a present directory entry (bit 0 = 1) arrives, one read is issued at {dir_entry[31:12], lin[21:12], 2'b00}.
- R5: Once a present table entry arrives, `rsp_done` pulses in the next cycle with `rsp_phys` = {tbl_entry[31:12], lin[11:0]}. A successful walk makes exactly two reads.
- R6: A directory entry whose bit 0 is 0 ends the walk with a `rsp_fault` pulse after exactly one read.
- R7: A table entry whose bit 0 is 0 ends the walk with a `rsp_fault` pulse after two reads.
- R8: On each fault, `fault_lin` takes the faulting linear address. It holds that value through later successful walks.
- R9: `req_ready` is 0 from acceptance of a paged request until its result pulse, so no request is taken during a walk.
- R10: A root-pointer write made while a walk is in progress does not change that walk. It applies to every request accepted after the write.
- R11: `mem_rd_en` is a single-cycle pulse with a word-aligned address (bits 1:0 = 0).
- R12: `rsp_done` and `rsp_fault` are never high together, and each lasts one cycle per request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| paging_en | input | 1 | 1 enables translation, 0 passes addresses through |
| root_wr | input | 1 | Write strobe for the root-pointer register |
| root_wdata | input | 32 | Directory base; bits 11:0 are ignored |
| req_valid | input | 1 | Translation request present |
| req_ready | output | 1 | Walker idle and able to take a request |
| req_lin | input | 32 | Linear address to translate |
| rsp_done | output | 1 | One-cycle pulse: translation succeeded |
| rsp_fault | output | 1 | One-cycle pulse: page fault (exception 14) |
| rsp_phys | output | 32 | Physical address, valid with `rsp_done` |
| fault_lin | output | 32 | Linear address of the latest fault |
| mem_rd_en | output | 1 | Memory read strobe |
| mem_rd_addr | output | 32 | Byte address of the entry being read |
| mem_rd_valid | input | 1 | Read data available |
| mem_rd_data | input | 32 | Entry read from memory |

## Verification
A walker that gets stuck in a busy state shows up at once: `req_ready` stays low, and the next request is never answered. A walker that returns to idle too early shows up as a result pulse with too few reads counted on the read port. A wrong index slice or a wrong base latch produces a read at the wrong address. The memory model then returns a non-present entry, so a fault pulse appears where a physical address was expected, within a few cycles of the request. A stale root snapshot or a fault-address register that fails to capture is visible in the very next result.

// File: rtl/pt_pkg.sv
package pt_pkg;
  typedef enum logic [1:0] {
    WALK_IDLE = 2'd0,
    WALK_DIR  = 2'd1,
    WALK_TBL  = 2'd2
  } walk_state_t;
endpackage

// File: rtl/pt_entry_addr.sv
// Forms the byte address of a table entry from a frame base and one index
// field of the linear address. LEVEL 0 selects the directory index, 1 the table index.
module pt_entry_addr #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int ENT_LOG2 = 2,
  parameter int LEVEL    = 0
) (
  input  logic [ADDR_W-OFF_W-1:0] base_frame,
  input  logic [ADDR_W-1:0]       lin,
  output logic [ADDR_W-1:0]       entry_addr
);
  localparam int IDX_W = OFF_W - ENT_LOG2;

  logic [IDX_W-1:0] idx;

  generate
    if (LEVEL == 0) begin : g_dir
      assign idx = lin[ADDR_W-1 -: IDX_W];
    end else begin : g_tbl
      assign idx = lin[OFF_W+IDX_W-1 -: IDX_W];
    end
  endgenerate

  assign entry_addr = {base_frame, idx, {ENT_LOG2{1'b0}}};

  logic unused_lin;
  generate
    if (LEVEL == 0) begin : g_u0
      assign unused_lin = ^lin[ADDR_W-IDX_W-1:0];
    end else begin : g_u1
      assign unused_lin = ^{lin[ADDR_W-1:OFF_W+IDX_W], lin[OFF_W-1:0]};
    end
  endgenerate
endmodule

// File: rtl/pt_root_reg.sv
// Root-pointer register: keeps only the frame bits of the directory base.
module pt_root_reg #(
  parameter int ADDR_W = 32,
  parameter int OFF_W  = 12
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    wr,
  input  logic [ADDR_W-1:0]       wdata,
  output logic [ADDR_W-OFF_W-1:0] frame
);
  always_ff @(posedge clk) begin
    if (rst)     frame <= '0;
    else if (wr) frame <= wdata[ADDR_W-1:OFF_W];
  end

  logic unused_low;
  assign unused_low = ^wdata[OFF_W-1:0];
endmodule

// File: rtl/pt_fault_reg.sv
// Fault-address register: captures the linear address of a failed walk.
module pt_fault_reg #(
  parameter int ADDR_W = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              capture,
  input  logic [ADDR_W-1:0] lin,
  output logic [ADDR_W-1:0] fault_lin
);
  always_ff @(posedge clk) begin
    if (rst)          fault_lin <= '0;
    else if (capture) fault_lin <= lin;
  end
endmodule

// File: rtl/pt_walk_fsm.sv
// Sequencer: idle -> directory read -> table read, one read per step.
module pt_walk_fsm
  import pt_pkg::*;
#(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int ENT_LOG2 = 2
) (
  input  logic                    clk,
  input  logic                    rst,
  input  logic                    paging_en,
  input  logic [ADDR_W-OFF_W-1:0] root_frame,
  input  logic                    req_valid,
  output logic                    req_ready,
  input  logic [ADDR_W-1:0]       req_lin,
  output logic                    rsp_done,
  output logic                    rsp_fault,
  output logic [ADDR_W-1:0]       rsp_phys,
  output logic                    fault_evt,
  output logic [ADDR_W-1:0]       walk_lin,
  output logic                    mem_rd_en,
  output logic [ADDR_W-1:0]       mem_rd_addr,
  input  logic                    mem_rd_valid,
  input  logic [ADDR_W-1:0]       mem_rd_data
);
  localparam int FRAME_W = ADDR_W - OFF_W;

  walk_state_t        state;
  logic [ADDR_W-1:0]  lin_q;
  logic [ADDR_W-1:0]  dir_addr;
  logic [ADDR_W-1:0]  tbl_addr;
  logic [FRAME_W-1:0] ent_frame;
  logic               ent_present;

  assign ent_frame   = mem_rd_data[ADDR_W-1:OFF_W];
  assign ent_present = mem_rd_data[0];

  pt_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENT_LOG2(ENT_LOG2), .LEVEL(0)) u_dir_addr (
    .base_frame (root_frame),
    .lin        (req_lin),
    .entry_addr (dir_addr)
  );

  pt_entry_addr #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENT_LOG2(ENT_LOG2), .LEVEL(1)) u_tbl_addr (
    .base_frame (ent_frame),
    .lin        (lin_q),
    .entry_addr (tbl_addr)
  );

  assign req_ready = (state == WALK_IDLE);
  assign walk_lin  = lin_q;
  assign fault_evt = mem_rd_valid && !ent_present &&
                     ((state == WALK_DIR) || (state == WALK_TBL));

  always_ff @(posedge clk) begin
    if (rst) begin
      state       <= WALK_IDLE;
      lin_q       <= '0;
      rsp_done    <= 1'b0;
      rsp_fault   <= 1'b0;
      rsp_phys    <= '0;
      mem_rd_en   <= 1'b0;
      mem_rd_addr <= '0;
    end else begin
      rsp_done  <= 1'b0;
      rsp_fault <= 1'b0;
      mem_rd_en <= 1'b0;
      case (state)
        WALK_IDLE: begin
          if (req_valid) begin
            lin_q <= req_lin;
            if (!paging_en) begin
              rsp_done <= 1'b1;
              rsp_phys <= req_lin;
            end else begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= dir_addr;
              state       <= WALK_DIR;
            end
          end
        end
        WALK_DIR: begin
          if (mem_rd_valid) begin
            if (!ent_present) begin
              rsp_fault <= 1'b1;
              state     <= WALK_IDLE;
            end else begin
              mem_rd_en   <= 1'b1;
              mem_rd_addr <= tbl_addr;
              state       <= WALK_TBL;
            end
          end
        end
        WALK_TBL: begin
          if (mem_rd_valid) begin
            if (!ent_present) begin
              rsp_fault <= 1'b1;
            end else begin
              rsp_done <= 1'b1;
              rsp_phys <= {ent_frame, lin_q[OFF_W-1:0]};
            end
            state <= WALK_IDLE;
          end
        end
        default: state <= WALK_IDLE;
      endcase
    end
  end

  logic unused_mid;
  assign unused_mid = ^mem_rd_data[OFF_W-1:1];
endmodule

// File: rtl/pt_walker.sv
module pt_walker #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int ENT_LOG2 = 2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              paging_en,
  input  logic              root_wr,
  input  logic [ADDR_W-1:0] root_wdata,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_lin,
  output logic              rsp_done,
  output logic              rsp_fault,
  output logic [ADDR_W-1:0] rsp_phys,
  output logic [ADDR_W-1:0] fault_lin,
  output logic              mem_rd_en,
  output logic [ADDR_W-1:0] mem_rd_addr,
  input  logic              mem_rd_valid,
  input  logic [ADDR_W-1:0] mem_rd_data
);
  localparam int FRAME_W = ADDR_W - OFF_W;

  logic [FRAME_W-1:0] root_frame;
  logic               fault_evt;
  logic [ADDR_W-1:0]  walk_lin;

  pt_root_reg #(.ADDR_W(ADDR_W), .OFF_W(OFF_W)) u_root (
    .clk   (clk),
    .rst   (rst),
    .wr    (root_wr),
    .wdata (root_wdata),
    .frame (root_frame)
  );

  pt_walk_fsm #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENT_LOG2(ENT_LOG2)) u_fsm (
    .clk          (clk),
    .rst          (rst),
    .paging_en    (paging_en),
    .root_frame   (root_frame),
    .req_valid    (req_valid),
    .req_ready    (req_ready),
    .req_lin      (req_lin),
    .rsp_done     (rsp_done),
    .rsp_fault    (rsp_fault),
    .rsp_phys     (rsp_phys),
    .fault_evt    (fault_evt),
    .walk_lin     (walk_lin),
    .mem_rd_en    (mem_rd_en),
    .mem_rd_addr  (mem_rd_addr),
    .mem_rd_valid (mem_rd_valid),
    .mem_rd_data  (mem_rd_data)
  );

  pt_fault_reg #(.ADDR_W(ADDR_W)) u_fault (
    .clk       (clk),
    .rst       (rst),
    .capture   (fault_evt),
    .lin       (walk_lin),
    .fault_lin (fault_lin)
  );
endmodule

// File: rtl/pt_walker_chk.sv
module pt_walker_chk #(
  parameter int ADDR_W   = 32,
  parameter int OFF_W    = 12,
  parameter int ENT_LOG2 = 2
) (
  input logic              clk,
  input logic              rst,
  input logic              paging_en,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_lin,
  input logic              rsp_done,
  input logic              rsp_fault,
  input logic [ADDR_W-1:0] rsp_phys,
  input logic [ADDR_W-1:0] fault_lin,
  input logic              mem_rd_en,
  input logic [ADDR_W-1:0] mem_rd_addr
);
  localparam int IDX_W = OFF_W - ENT_LOG2;

  assert_bypass_R2: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && !paging_en) |=> (rsp_done && !mem_rd_en && rsp_phys == $past(req_lin)));

  assert_dir_index_R3: assert property (@(posedge clk) disable iff (rst)
    (req_valid && req_ready && paging_en) |=>
      (mem_rd_en && mem_rd_addr[OFF_W-1:ENT_LOG2] == $past(req_lin[ADDR_W-1 -: IDX_W])));

  assert_busy_R9: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> !req_ready);

  assert_read_pulse_R11: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |=> !mem_rd_en);

  assert_read_align_R11: assert property (@(posedge clk) disable iff (rst)
    mem_rd_en |-> (mem_rd_addr[ENT_LOG2-1:0] == '0));

  assert_exclusive_R12: assert property (@(posedge clk) disable iff (rst)
    !(rsp_done && rsp_fault));

  assert_fault_idle_R6: assert property (@(posedge clk) disable iff (rst)
    rsp_fault |-> (req_ready && !mem_rd_en));

  assert_fault_hold_R8: assert property (@(posedge clk) disable iff (rst)
    !rsp_fault |-> $stable(fault_lin));
endmodule

bind pt_walker pt_walker_chk #(.ADDR_W(ADDR_W), .OFF_W(OFF_W), .ENT_LOG2(ENT_LOG2)) u_chk (
  .clk         (clk),
  .rst         (rst),
  .paging_en   (paging_en),
  .req_valid   (req_valid),
  .req_ready   (req_ready),
  .req_lin     (req_lin),
  .rsp_done    (rsp_done),
  .rsp_fault   (rsp_fault),
  .rsp_phys    (rsp_phys),
  .fault_lin   (fault_lin),
  .mem_rd_en   (mem_rd_en),
  .mem_rd_addr (mem_rd_addr)
);

// File: tb/pt_walker_tb_top.sv
`timescale 1ns/1ps
module pt_walker_tb_top;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        paging_en = 1'b0;
  logic        root_wr = 1'b0;
  logic [31:0] root_wdata = '0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [31:0] req_lin = '0;
  logic        rsp_done, rsp_fault;
  logic [31:0] rsp_phys, fault_lin;
  logic        mem_rd_en;
  logic [31:0] mem_rd_addr;
  logic        mem_rd_valid = 1'b0;
  logic [31:0] mem_rd_data = '0;

  always #10 clk = ~clk;

  pt_walker dut_i (
    .clk(clk), .rst(rst), .paging_en(paging_en), .root_wr(root_wr),
    .root_wdata(root_wdata), .req_valid(req_valid), .req_ready(req_ready),
    .req_lin(req_lin), .rsp_done(rsp_done), .rsp_fault(rsp_fault),
    .rsp_phys(rsp_phys), .fault_lin(fault_lin), .mem_rd_en(mem_rd_en),
    .mem_rd_addr(mem_rd_addr), .mem_rd_valid(mem_rd_valid), .mem_rd_data(mem_rd_data)
  );

  typedef struct {
    bit          flt;
    logic [31:0] phys;
    logic [31:0] lin;
    int          nrd;
  } exp_t;

  exp_t        sb_q[$];
  logic [31:0] mem [logic [31:0]];
  int          n_tests = 0;
  int          n_fail  = 0;
  int          reads   = 0;
  logic [31:0] root_model = '0;
  bit          pg_model = 1'b0;
  logic [31:0] last_fault = '0;
  logic [31:0] pend_addr = '0;
  int          pend = 0;

  function automatic logic [31:0] rd(input logic [31:0] a);
    return mem.exists(a) ? mem[a] : 32'h0;
  endfunction

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] expv);
    n_tests++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", req, act, expv);
    end
  endtask

  // Memory model: answers each read two cycles later.
  always @(negedge clk) begin
    mem_rd_valid = 1'b0;
    if (pend > 0) begin
      pend--;
      if (pend == 0) begin
        mem_rd_valid = 1'b1;
        mem_rd_data  = rd(pend_addr);
      end
    end
    if (!rst && mem_rd_en) begin
      pend_addr = mem_rd_addr;
      pend = 2;
      reads++;
    end
  end

  // Monitor: compares each result pulse with the scoreboard head.
  always @(negedge clk) begin
    if (!rst && (rsp_done || rsp_fault)) begin
      if (sb_q.size() == 0) begin
        check(1'b0, "R12 unexpected result", {31'b0, rsp_done}, 32'h0);
      end else begin
        exp_t e;
        e = sb_q.pop_front();
        check(rsp_fault == e.flt, "R5/R6/R7 fault flag", {31'b0, rsp_fault}, {31'b0, e.flt});
        check(!(rsp_done && rsp_fault), "R12 done and fault together", {31'b0, rsp_fault}, 32'h0);
        if (e.flt) begin
          check(fault_lin == e.lin, "R8 fault address", fault_lin, e.lin);
          last_fault = e.lin;
        end else begin
          check(rsp_phys == e.phys, "R2/R3/R4/R5 physical address", rsp_phys, e.phys);
        end
      end
    end
  end

  task automatic do_req(input logic [31:0] lin);
    exp_t e;
    logic [31:0] de, te;
    int r0;
    e.lin = lin; e.flt = 1'b0; e.phys = lin; e.nrd = 0;
    if (pg_model) begin
      de = rd({root_model[31:12], lin[31:22], 2'b00});
      e.nrd = 1;
      if (!de[0]) e.flt = 1'b1;
      else begin
        te = rd({de[31:12], lin[21:12], 2'b00});
        e.nrd = 2;
        if (!te[0]) e.flt = 1'b1;
        else e.phys = {te[31:12], lin[11:0]};
      end
    end
    sb_q.push_back(e);
    r0 = reads;
    @(negedge clk);
    req_valid = 1'b1;
    req_lin = lin;
    while (!req_ready) @(negedge clk);
    @(negedge clk);
    req_valid = 1'b0;
    if (pg_model) check(req_ready == 1'b0, "R9 ready low while walking", {31'b0, req_ready}, 32'h0);
    while (sb_q.size() != 0) @(negedge clk);
    check(reads - r0 == e.nrd, "R2/R5/R6/R7 read count", reads - r0, e.nrd);
    @(negedge clk);
    check(!rsp_done && !rsp_fault, "R12 single-cycle pulse", {30'b0, rsp_done, rsp_fault}, 32'h0);
    check(fault_lin == last_fault, "R8 fault address held", fault_lin, last_fault);
    check(req_ready, "R9 ready after result", {31'b0, req_ready}, 32'h1);
  endtask

  task automatic write_root(input logic [31:0] v);
    @(negedge clk);
    root_wr = 1'b1;
    root_wdata = v;
    @(negedge clk);
    root_wr = 1'b0;
    root_model = v;
  endtask

  task automatic set_paging(input bit v);
    @(negedge clk);
    paging_en = v;
    pg_model = v;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++;
    n_fail++;
    $display("FAIL watchdog actual=%h expected=%h", 32'h1, 32'h0);
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  initial begin
    mem[32'h0010_0014] = 32'h0020_0001;
    mem[32'h0010_0FFC] = 32'h0040_0001;
    mem[32'h0020_001C] = 32'hABCD_E001;
    mem[32'h0020_0000] = 32'h1234_5001;
    mem[32'h0020_0FFC] = 32'hFFFF_F001;
    mem[32'h0020_0020] = 32'h7777_7000;
    mem[32'h0040_0FFC] = 32'h5555_5001;
    mem[32'h0030_0014] = 32'h0050_0001;
    mem[32'h0050_001C] = 32'h0BEE_F001;

    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1: reset state
    check(req_ready == 1'b1, "R1 ready", {31'b0, req_ready}, 32'h1);
    check(rsp_done == 1'b0, "R1 done", {31'b0, rsp_done}, 32'h0);
    check(rsp_fault == 1'b0, "R1 fault", {31'b0, rsp_fault}, 32'h0);
    check(mem_rd_en == 1'b0, "R1 read strobe", {31'b0, mem_rd_en}, 32'h0);
    check(fault_lin == 32'h0, "R1 fault address", fault_lin, 32'h0);

    // R2: pass-through
    do_req(32'h0140_7345);
    do_req(32'hDEAD_BEEF);

    write_root(32'h0010_0ABC);  // low bits ignored
    set_paging(1'b1);
    // R3 R4 R5: walks with several index and offset patterns
    do_req(32'h0140_7345);
    do_req(32'h0140_0000);
    do_req(32'h017F_FFFF);
    do_req(32'hFFFF_FFFF);
    // R7: table entry not present
    do_req(32'h0140_8010);
    // R6: directory entry not present
    do_req(32'h0000_0123);
    // R8: fault address kept across a good walk
    do_req(32'h0140_7345);

    // R10: root write during a walk
    fork
      do_req(32'h0140_7345);
      begin
        repeat (2) @(negedge clk);
        root_wr = 1'b1;
        root_wdata = 32'h0030_0000;
        @(negedge clk);
        root_wr = 1'b0;
      end
    join
    root_model = 32'h0030_0000;
    do_req(32'h0140_7345);

    set_paging(1'b0);
    do_req(32'h0000_0123);  // R2 again after paging

    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule